// File: doc/BRIEF.md
# Cache Maintenance Command Queue Front-End

This block sits between several processor masters and one cache maintenance engine. The masters share one set of command registers: mode, start address, size and way mask. A master claims these registers by writing the mode word. It then fills in the operands it needs. It commits the command by reading its own registration-status word. Committed commands go into a FIFO. They are handed to the cache side one at a time over a request/acknowledge port. The command carries the identity of the master that issued it.

Each master has its own registration-status word, which reports an ownership collision or a full queue. Each master also has its own completion word, which holds a sticky done flag and live execution and queue bits. A separate primitive register requests a buffer-drain sync (code 8) or a prefetch-buffer flush (code 9). These run on the cache port once every queued command has finished. A read of the primitive register holds its response until the primitive has been acknowledged.

The register port takes one request per cycle with a master-ID field. A read returns one cycle after acceptance, except the held primitive readback.

Top module: `cmq_frontend`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `cq_valid` is 0.
- R2: Every accepted request gets `rsp_valid` in the next cycle, except a read of the primitive register while a primitive is outstanding. While that read is held, `req_ready` is 0 and `rsp_valid` is 0.
- R3: Register word indices on `req_reg` are: 0 mode, 1 address, 2 size, 3 way mask, 4 registration status, 5 completion, 6 primitive. The first master to write the mode word while no one owns the command registers becomes the owner. A write to words 0 to 3 by any other master is ignored and sets bit 0 of that master's registration-status word. Reading word 4 returns the flags and then clears them.
- R4: When the owner reads word 4, the command is committed and ownership is released. If the FIFO is full at that moment, nothing is queued and the read returns bit 1 set.
- R5: Mode word fields: bits [22:21] target (2 = explicit ways), bits [18:17] scope (0 = address range, 1 = whole cache), bit 15 notify, bits [3:0] command code. These fields reach `cq_target`, `cq_scope` and `cq_code` unchanged.
- R6: The cache port shows zero address and size unless scope is 0. It shows a zero way mask unless target is 2.
- R7: Commands execute one at a time, in commit order across all masters. `cq_valid` stays high with stable fields until `cq_ack`.
- R8: Completion word (index 5) bits: bit 2 is set when a command with notify finishes; bit 1 means one of this master's commands is on the cache port; bit 0 means this master has a command outstanding. Writing 1 to bit 2 clears the flag.
- R9: Writing 8 or 9 to word 6 issues, after all queued commands, one cache request with `cq_prim` = 1 and that code. Any other value is ignored.
- R10: A read of word 6 returns the last accepted primitive code. If a primitive is outstanding, the response waits until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mid | input | MID_W | Issuing master |
| req_reg | input | 3 | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| cq_valid | output | 1 | Cache-side request valid |
| cq_ack | input | 1 | Cache-side completion |
| cq_prim | output | 1 | Request is a primitive |
| cq_code | output | 4 | Command or primitive code |
| cq_target | output | 2 | Target field |
| cq_scope | output | 2 | Scope field |
| cq_mid | output | MID_W | Issuing master |
| cq_addr | output | AW | Start address |
| cq_size | output | AW | Size |
| cq_ways | output | NWAYS | Way mask |

## Verification
The bench lets a second master write the mode and address words while a first master owns them. If ownership were not exclusive, the second master's address would corrupt the owner's command, or its fail flag would stay clear.

It holds the cache acknowledge off until the FIFO fills. A design that dropped the full check would queue a sixth command or report success.

It reads the primitive register while the queue is still full. A design that answered at once, or issued the sync ahead of queued work, would break the stall check or the ordering check. It also sends a non-primitive code to word 6; a design without filtering would put a stray request on the cache port.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

  typedef enum logic [2:0] {
    RG_MODE   = 3'd0,
    RG_ADDR   = 3'd1,
    RG_SIZE   = 3'd2,
    RG_WAYS   = 3'd3,
    RG_REGST  = 3'd4,
    RG_DONEST = 3'd5,
    RG_PRIM   = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic [1:0] target;
    logic [1:0] scope;
    logic       notify;
    logic [3:0] code;
  } mode_t;

  typedef enum logic [1:0] {
    EX_IDLE = 2'd0,
    EX_LOAD = 2'd1,
    EX_CMD  = 2'd2,
    EX_PRIM = 2'd3
  } ex_state_e;

  localparam logic [1:0] TGT_WAYS    = 2'd2;
  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [3:0] PRIM_SYNC   = 4'd8;
  localparam logic [3:0] PRIM_PFFL   = 4'd9;

  function automatic mode_t decode_mode(input logic [31:0] w);
    mode_t m;
    m.target = w[22:21];
    m.scope  = w[18:17];
    m.notify = w[15];
    m.code   = w[3:0];
    return m;
  endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
    if (pop)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cmq_regs.sv
module cmq_regs
  import cmq_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int MID_W     = 2,
  parameter int AW        = 32,
  parameter int NWAYS     = 8,
  parameter int DEPTH     = 4,
  parameter int ENTRY_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [MID_W-1:0]   req_mid,
  input  logic [2:0]         req_reg,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  input  logic               fifo_full,
  output logic               push,
  output logic [ENTRY_W-1:0] push_data,
  output logic               sync_req,
  output logic [3:0]         sync_code,
  input  logic               exec_run,
  input  logic [MID_W-1:0]   exec_mid,
  input  logic               done_v,
  input  logic [MID_W-1:0]   done_mid,
  input  logic               done_notify,
  input  logic               sync_busy
);
  localparam int PCW = $clog2(DEPTH + 2);

  logic                 own_v;
  logic [MID_W-1:0]     own_mid;
  mode_t                mode_q;
  logic [AW-1:0]        addr_q, size_q;
  logic [NWAYS-1:0]     ways_q;
  logic [N_MASTERS-1:0] ovr_q, flag_q, outstanding;
  logic                 stall_q;
  logic [3:0]           prim_q;

  logic       acc, is_owner, may_write, commit, mid_ok, prim_ok;
  reg_idx_e   rg;

  assign req_ready = !stall_q;
  assign acc       = req_valid && req_ready;
  assign rg        = reg_idx_e'(req_reg);
  assign mid_ok    = (int'(req_mid) < N_MASTERS);
  assign is_owner  = own_v && (own_mid == req_mid);
  assign may_write = !own_v || is_owner;
  assign commit    = acc && !req_write && (rg == RG_REGST) && is_owner;
  assign push      = commit && !fifo_full;
  assign prim_ok   = (req_wdata[31:4] == '0) &&
                     ((req_wdata[3:0] == PRIM_SYNC) || (req_wdata[3:0] == PRIM_PFFL));
  assign sync_req  = acc && req_write && (rg == RG_PRIM) && prim_ok && !sync_busy;
  assign sync_code = req_wdata[3:0];

  assign push_data = {own_mid, mode_q,
                      (mode_q.scope == SCOPE_RANGE) ? addr_q : {AW{1'b0}},
                      (mode_q.scope == SCOPE_RANGE) ? size_q : {AW{1'b0}},
                      (mode_q.target == TGT_WAYS)   ? ways_q : {NWAYS{1'b0}}};

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_pend
    logic [PCW-1:0] cnt;
    logic           inc, dec;
    assign inc = push   && (own_mid  == MID_W'(g));
    assign dec = done_v && (done_mid == MID_W'(g));
    always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (inc && !dec)  cnt <= cnt + 1'b1;
      else if (dec && !inc)  cnt <= cnt - 1'b1;
    end
    assign outstanding[g] = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v     <= 1'b0;
      own_mid   <= '0;
      mode_q    <= '0;
      addr_q    <= '0;
      size_q    <= '0;
      ways_q    <= '0;
      ovr_q     <= '0;
      flag_q    <= '0;
      stall_q   <= 1'b0;
      prim_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (stall_q && !sync_busy) begin
        stall_q   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= {28'd0, prim_q};
      end
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
        if (mid_ok) begin
          case (rg)
            RG_MODE, RG_ADDR, RG_SIZE, RG_WAYS: begin
              if (req_write) begin
                if (!may_write || (rg != RG_MODE && !is_owner)) begin
                  ovr_q[req_mid] <= 1'b1;
                end else begin
                  case (rg)
                    RG_MODE: begin
                      own_v   <= 1'b1;
                      own_mid <= req_mid;
                      mode_q  <= decode_mode(req_wdata);
                    end
                    RG_ADDR: addr_q <= req_wdata[AW-1:0];
                    RG_SIZE: size_q <= req_wdata[AW-1:0];
                    default: ways_q <= req_wdata[NWAYS-1:0];
                  endcase
                end
              end
            end
            RG_REGST: if (!req_write) begin
              rsp_rdata      <= {30'd0, commit && fifo_full, ovr_q[req_mid]};
              ovr_q[req_mid] <= 1'b0;
              if (commit) own_v <= 1'b0;
            end
            RG_DONEST: begin
              if (req_write) begin
                if (req_wdata[2]) flag_q[req_mid] <= 1'b0;
              end else begin
                rsp_rdata <= {29'd0, flag_q[req_mid],
                              exec_run && (exec_mid == req_mid),
                              outstanding[req_mid]};
              end
            end
            RG_PRIM: begin
              if (req_write) begin
                if (sync_req) prim_q <= req_wdata[3:0];
              end else if (sync_busy) begin
                stall_q   <= 1'b1;
                rsp_valid <= 1'b0;
              end else begin
                rsp_rdata <= {28'd0, prim_q};
              end
            end
            default: ;
          endcase
        end
      end
      if (done_v && done_notify) flag_q[done_mid] <= 1'b1;
    end
  end
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
  import cmq_pkg::*;
#(
  parameter int MID_W   = 2,
  parameter int AW      = 32,
  parameter int NWAYS   = 8,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_empty,
  input  logic [ENTRY_W-1:0] fifo_rdata,
  output logic               pop,
  input  logic               sync_req,
  input  logic [3:0]         sync_code,
  output logic               sync_busy,
  output logic               exec_run,
  output logic               done_v,
  output logic [MID_W-1:0]   done_mid,
  output logic               done_notify,
  output logic               cq_valid,
  input  logic               cq_ack,
  output logic               cq_prim,
  output logic [3:0]         cq_code,
  output logic [1:0]         cq_target,
  output logic [1:0]         cq_scope,
  output logic [MID_W-1:0]   cq_mid,
  output logic [AW-1:0]      cq_addr,
  output logic [AW-1:0]      cq_size,
  output logic [NWAYS-1:0]   cq_ways
);
  ex_state_e        state;
  logic             sync_pend, notify_q;
  logic [3:0]       sync_code_q;
  logic [MID_W-1:0] e_mid;
  mode_t            e_mode;
  logic [AW-1:0]    e_addr, e_size;
  logic [NWAYS-1:0] e_ways;

  assign {e_mid, e_mode, e_addr, e_size, e_ways} = fifo_rdata;
  assign pop       = (state == EX_IDLE) && !fifo_empty;
  assign sync_busy = sync_pend;
  assign exec_run  = (state == EX_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= EX_IDLE;
      sync_pend   <= 1'b0;
      sync_code_q <= '0;
      notify_q    <= 1'b0;
      done_v      <= 1'b0;
      done_mid    <= '0;
      done_notify <= 1'b0;
      cq_valid    <= 1'b0;
      cq_prim     <= 1'b0;
      cq_code     <= '0;
      cq_target   <= '0;
      cq_scope    <= '0;
      cq_mid      <= '0;
      cq_addr     <= '0;
      cq_size     <= '0;
      cq_ways     <= '0;
    end else begin
      done_v <= 1'b0;
      if (sync_req) begin
        sync_pend   <= 1'b1;
        sync_code_q <= sync_code;
      end
      case (state)
        EX_IDLE: begin
          if (!fifo_empty) begin
            state <= EX_LOAD;
          end else if (sync_pend) begin
            cq_valid  <= 1'b1;
            cq_prim   <= 1'b1;
            cq_code   <= sync_code_q;
            cq_target <= '0;
            cq_scope  <= '0;
            cq_mid    <= '0;
            cq_addr   <= '0;
            cq_size   <= '0;
            cq_ways   <= '0;
            state     <= EX_PRIM;
          end
        end
        EX_LOAD: begin
          cq_valid  <= 1'b1;
          cq_prim   <= 1'b0;
          cq_code   <= e_mode.code;
          cq_target <= e_mode.target;
          cq_scope  <= e_mode.scope;
          cq_mid    <= e_mid;
          cq_addr   <= e_addr;
          cq_size   <= e_size;
          cq_ways   <= e_ways;
          notify_q  <= e_mode.notify;
          state     <= EX_CMD;
        end
        EX_CMD: if (cq_ack) begin
          cq_valid    <= 1'b0;
          done_v      <= 1'b1;
          done_mid    <= cq_mid;
          done_notify <= notify_q;
          state       <= EX_IDLE;
        end
        EX_PRIM: if (cq_ack) begin
          cq_valid  <= 1'b0;
          sync_pend <= 1'b0;
          state     <= EX_IDLE;
        end
        default: state <= EX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
  import cmq_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int MID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter int DEPTH     = 4,
  parameter int AW        = 32,
  parameter int NWAYS     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [MID_W-1:0] req_mid,
  input  logic [2:0]       req_reg,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             cq_valid,
  input  logic             cq_ack,
  output logic             cq_prim,
  output logic [3:0]       cq_code,
  output logic [1:0]       cq_target,
  output logic [1:0]       cq_scope,
  output logic [MID_W-1:0] cq_mid,
  output logic [AW-1:0]    cq_addr,
  output logic [AW-1:0]    cq_size,
  output logic [NWAYS-1:0] cq_ways
);
  localparam int ENTRY_W = MID_W + $bits(mode_t) + 2 * AW + NWAYS;

  logic               push, pop, fifo_full, fifo_empty;
  logic [ENTRY_W-1:0] push_data, fifo_rdata;
  logic               sync_req, sync_busy, exec_run;
  logic [3:0]         sync_code;
  logic               done_v, done_notify;
  logic [MID_W-1:0]   done_mid;

  cmq_regs #(
    .N_MASTERS(N_MASTERS), .MID_W(MID_W), .AW(AW), .NWAYS(NWAYS),
    .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_mid(req_mid), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fifo_full(fifo_full), .push(push), .push_data(push_data),
    .sync_req(sync_req), .sync_code(sync_code),
    .exec_run(exec_run), .exec_mid(cq_mid),
    .done_v(done_v), .done_mid(done_mid), .done_notify(done_notify),
    .sync_busy(sync_busy)
  );

  cmq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(push_data),
    .pop(pop), .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  cmq_exec #(.MID_W(MID_W), .AW(AW), .NWAYS(NWAYS), .ENTRY_W(ENTRY_W)) u_exec (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .pop(pop), .sync_req(sync_req), .sync_code(sync_code),
    .sync_busy(sync_busy), .exec_run(exec_run),
    .done_v(done_v), .done_mid(done_mid), .done_notify(done_notify),
    .cq_valid(cq_valid), .cq_ack(cq_ack), .cq_prim(cq_prim),
    .cq_code(cq_code), .cq_target(cq_target), .cq_scope(cq_scope),
    .cq_mid(cq_mid), .cq_addr(cq_addr), .cq_size(cq_size), .cq_ways(cq_ways)
  );
endmodule

// File: rtl/cmq_checker.sv
module cmq_checker #(
  parameter int MID_W = 2,
  parameter int AW    = 32,
  parameter int NWAYS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             cq_valid,
  input logic             cq_ack,
  input logic             cq_prim,
  input logic [3:0]       cq_code,
  input logic [1:0]       cq_target,
  input logic [1:0]       cq_scope,
  input logic [MID_W-1:0] cq_mid,
  input logic [AW-1:0]    cq_addr,
  input logic [AW-1:0]    cq_size,
  input logic [NWAYS-1:0] cq_ways
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> (req_ready && !rsp_valid && !cq_valid));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || !req_ready));

  // R2
  held_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !rsp_valid);

  // R7
  cq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && !cq_ack) |=> (cq_valid && $stable(cq_code) && $stable(cq_mid)
                               && $stable(cq_addr) && $stable(cq_prim)));

  // R9
  prim_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && cq_prim) |-> (cq_code == 4'd8 || cq_code == 4'd9));

  // R6
  range_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && !cq_prim && cq_scope != 2'd0) |-> (cq_addr == '0 && cq_size == '0));

  // R6
  way_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_valid && !cq_prim && cq_target != 2'd2) |-> (cq_ways == '0));
endmodule

bind cmq_frontend cmq_checker #(.MID_W(MID_W), .AW(AW), .NWAYS(NWAYS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .cq_valid(cq_valid), .cq_ack(cq_ack),
  .cq_prim(cq_prim), .cq_code(cq_code), .cq_target(cq_target),
  .cq_scope(cq_scope), .cq_mid(cq_mid), .cq_addr(cq_addr),
  .cq_size(cq_size), .cq_ways(cq_ways)
);

// File: tb/tb_cmq_frontend.sv
module tb_cmq_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int MID_W = 2;
  localparam int AW    = 32;
  localparam int NWAYS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [MID_W-1:0] req_mid = '0;
  logic [2:0]  req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic cq_valid, cq_prim;
  logic cq_ack = 1'b0;
  logic [3:0] cq_code;
  logic [1:0] cq_target, cq_scope;
  logic [MID_W-1:0] cq_mid;
  logic [AW-1:0] cq_addr, cq_size;
  logic [NWAYS-1:0] cq_ways;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmq_frontend #(.N_MASTERS(4), .DEPTH(4), .AW(AW), .NWAYS(NWAYS)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mid(req_mid), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cq_valid(cq_valid), .cq_ack(cq_ack), .cq_prim(cq_prim),
    .cq_code(cq_code), .cq_target(cq_target), .cq_scope(cq_scope),
    .cq_mid(cq_mid), .cq_addr(cq_addr), .cq_size(cq_size), .cq_ways(cq_ways)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cache-side model: acknowledges after ack_dly cycles when enabled, logs requests
  logic ack_en = 1'b1;
  int   ack_dly = 2, hold = 0, n_log = 0;
  logic        lg_prim [32];
  logic [3:0]  lg_code [32];
  logic [1:0]  lg_tgt  [32], lg_scp [32];
  logic [1:0]  lg_mid  [32];
  logic [31:0] lg_addr [32], lg_size [32];
  logic [7:0]  lg_ways [32];

  initial begin
    forever begin
      @(negedge clk);
      if (cq_ack) cq_ack = 1'b0;
      else if (cq_valid && ack_en) begin
        if (hold >= ack_dly) begin
          lg_prim[n_log] = cq_prim; lg_code[n_log] = cq_code;
          lg_tgt[n_log] = cq_target; lg_scp[n_log] = cq_scope;
          lg_mid[n_log] = cq_mid; lg_addr[n_log] = cq_addr;
          lg_size[n_log] = cq_size; lg_ways[n_log] = cq_ways;
          n_log++;
          hold = 0;
          cq_ack = 1'b1;
        end else hold++;
      end
    end
  end

  task automatic bus(input logic wr, input logic [1:0] mid, input logic [2:0] rg,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mid = mid; req_reg = rg; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  mid;
    logic [2:0]  rg;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 2'd0, 3'd0, 32'h0000_8002, 1'b0, 32'h0},  // M0 claims: range, notify, flush
    '{1'b1, 2'd1, 3'd0, 32'h0000_0001, 1'b0, 32'h0},  // M1 mode write refused
    '{1'b1, 2'd0, 3'd1, 32'h0000_1000, 1'b0, 32'h0},
    '{1'b1, 2'd1, 3'd1, 32'hDEAD_0000, 1'b0, 32'h0},  // R3 ignored address write
    '{1'b1, 2'd0, 3'd2, 32'h0000_0040, 1'b0, 32'h0},
    '{1'b0, 2'd1, 3'd4, 32'h0,         1'b1, 32'h1},  // R3 fail flag
    '{1'b0, 2'd1, 3'd4, 32'h0,         1'b1, 32'h0},  // R3 cleared by read
    '{1'b0, 2'd0, 3'd4, 32'h0,         1'b1, 32'h0},  // R4 commit ok
    '{1'b1, 2'd1, 3'd0, 32'h0042_8005, 1'b0, 32'h0},  // ways, whole, notify, touch
    '{1'b1, 2'd1, 3'd3, 32'h0000_000F, 1'b0, 32'h0},
    '{1'b1, 2'd1, 3'd1, 32'h0000_2000, 1'b0, 32'h0},
    '{1'b0, 2'd1, 3'd4, 32'h0,         1'b1, 32'h0}   // R4 commit ok
  };

  initial begin
    repeat (4000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base, quiet_bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req_ready", 32'(req_ready), 32'h1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 cq_valid",  32'(cq_valid),  32'h0);

    for (int i = 0; i < 12; i++) begin
      bus(VEC[i].wr, VEC[i].mid, VEC[i].rg, VEC[i].data, rd);
      if (VEC[i].chk) check($sformatf("R3/R4 vector %0d", i), rd, VEC[i].exp);
    end
    repeat (20) @(negedge clk);

    check("R7 two commands", 32'(n_log), 32'd2);
    check("R7 first mid",  32'(lg_mid[0]), 32'd0);
    check("R5 first code", 32'(lg_code[0]), 32'd2);
    check("R3 owner addr kept", lg_addr[0], 32'h1000);
    check("R6 range size", lg_size[0], 32'h40);
    check("R6 ways zeroed", 32'(lg_ways[0]), 32'h0);
    check("R7 second mid", 32'(lg_mid[1]), 32'd1);
    check("R5 target", 32'(lg_tgt[1]), 32'd2);
    check("R5 scope",  32'(lg_scp[1]), 32'd1);
    check("R5 code",   32'(lg_code[1]), 32'd5);
    check("R6 whole addr zero", lg_addr[1], 32'h0);
    check("R6 ways kept", 32'(lg_ways[1]), 32'h0F);

    bus(1'b0, 2'd0, 3'd5, 0, rd); check("R8 M0 done flag", rd, 32'h4);
    bus(1'b0, 2'd1, 3'd5, 0, rd); check("R8 M1 done flag", rd, 32'h4);
    bus(1'b1, 2'd0, 3'd5, 32'h4, rd);
    bus(1'b0, 2'd0, 3'd5, 0, rd); check("R8 M0 flag cleared", rd, 32'h0);
    bus(1'b0, 2'd1, 3'd5, 0, rd); check("R8 M1 flag untouched", rd, 32'h4);

    // fill the queue with the cache side stalled
    ack_en = 1'b0;
    base = n_log;
    for (int k = 0; k < 5; k++) begin
      bus(1'b1, 2'd2, 3'd0, 32'h0002_0000, rd);
      bus(1'b0, 2'd2, 3'd4, 0, rd);
      check($sformatf("R4 commit %0d", k), rd, 32'h0);
    end
    bus(1'b1, 2'd2, 3'd0, 32'h0002_0003, rd);
    bus(1'b0, 2'd2, 3'd4, 0, rd); check("R4 full reported", rd, 32'h2);
    bus(1'b0, 2'd2, 3'd5, 0, rd); check("R8 running+queued", rd, 32'h3);
    bus(1'b0, 2'd3, 3'd5, 0, rd); check("R8 idle master", rd, 32'h0);

    // sync with a held readback
    bus(1'b1, 2'd3, 3'd6, 32'h8, rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mid = 2'd3; req_reg = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    quiet_bad = 0;
    for (int c = 0; c < 20; c++) begin
      if (rsp_valid || req_ready) quiet_bad++;
      @(negedge clk);
    end
    check("R10 readback held", 32'(quiet_bad), 32'd0);
    ack_en = 1'b1;
    while (!rsp_valid) @(negedge clk);
    check("R10 readback value", rsp_rdata, 32'h8);
    check("R9 queue drained first", 32'(n_log - base), 32'd6);
    check("R7 queued mid", 32'(lg_mid[base + 4]), 32'd2);
    check("R7 queued not prim", 32'(lg_prim[base + 4]), 32'd0);
    check("R9 sync last prim", 32'(lg_prim[base + 5]), 32'd1);
    check("R9 sync code", 32'(lg_code[base + 5]), 32'd8);
    repeat (5) @(negedge clk);
    bus(1'b0, 2'd2, 3'd5, 0, rd); check("R8 no notify", rd, 32'h0);

    base = n_log;
    bus(1'b1, 2'd0, 3'd6, 32'h3, rd);
    repeat (10) @(negedge clk);
    check("R9 bad code ignored", 32'(n_log - base), 32'd0);
    bus(1'b1, 2'd0, 3'd6, 32'h9, rd);
    bus(1'b0, 2'd0, 3'd6, 0, rd); check("R10 prefetch flush readback", rd, 32'h9);
    check("R9 flush issued", 32'(n_log - base), 32'd1);
    check("R9 flush code", 32'(lg_code[base]), 32'd9);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule